// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block decides when a small multicycle processor leaves its normal instruction flow for a handler, and how it comes back. The datapath reports two synchronous trap conditions (an undefined instruction and an arithmetic overflow), and a level-sensitive interrupt request line arrives from outside the core. When an event is accepted, the block latches a cause code and the program counter of the affected instruction. It moves the core into supervisor mode, masks interrupts, and sends a one-cycle redirect carrying the address the fetch unit must load next.

The handler entry address comes from one of two schemes, chosen by a one-bit select input. In fixed entry, every cause jumps to one handler address. In vectored entry, each cause gets its own 32-instruction slot: a base address plus the cause code shifted left by seven. A return-from-exception strobe restores the saved privilege mode and re-enables interrupts on the same clock edge. It then redirects fetch to the saved program counter. The redirect is a plain pulse with no back-pressure: the fetch unit must take the target in the cycle it is shown. All other pins are plain control and status levels.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, the block is in user mode (`kernel_o`=0) with interrupts masked (`int_en_o`=0). `in_handler_o`, `nested_o` and `redirect_valid_o` are 0, and `cause_o` and `epc_o` read 0.
- R2: An accepted event is visible on the next clock edge. `redirect_valid_o` goes high for that cycle, `epc_o` holds the `pc_i` value sampled with the event, and `cause_o` holds 0 for an undefined instruction, 1 for an overflow or 2 for an interrupt.
- R3: On the edge that accepts any event, `kernel_o` becomes 1, `int_en_o` becomes 0 and `in_handler_o` becomes 1.
- R4: With `vec_mode_i`=0 the target is 0x80000080. With `vec_mode_i`=1 it is 0x80 + (cause << 7), so causes 0, 1 and 2 land at 0x80, 0x100 and 0x180.
- R5: `irq_i` is ignored while `int_en_o` is 0: no redirect and no state change. While `int_en_o` is 1 it is accepted with cause 2.
- R6: The priority is fixed: undefined instruction, then overflow, then interrupt. A losing interrupt is not lost: it is taken later if `irq_i` is still high once interrupts are enabled.
- R7: `eret_i` without a trap in the same cycle does the following on the next edge. It pulses `redirect_valid_o` with the target equal to `epc_o`, restores `kernel_o` to the value it had before the last entry, sets `int_en_o` to 1 and clears `in_handler_o`.
- R8: A trap accepted while `in_handler_o` is 1 is still taken, and it raises `nested_o` for one cycle.
- R9: When a trap and `eret_i` arrive in the same cycle, the trap wins and the return is dropped.
- R10: With no event and no return, `redirect_valid_o` stays 0 and `cause_o`, `epc_o`, `kernel_o` and `int_en_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_mode_i | input | 1 | 1 selects per-cause vectored entry, 0 selects the single fixed entry |
| pc_i | input | 32 | Program counter of the instruction in progress |
| trap_undef_i | input | 1 | Undefined instruction detected this cycle |
| trap_ovf_i | input | 1 | Arithmetic overflow detected this cycle |
| irq_i | input | 1 | Level interrupt request |
| eret_i | input | 1 | Return-from-exception strobe |
| redirect_valid_o | output | 1 | One-cycle pulse: load `redirect_target_o` into the PC |
| redirect_target_o | output | 32 | Next fetch address for a redirect |
| cause_o | output | 2 | Cause code of the last accepted event |
| epc_o | output | 32 | Saved program counter |
| kernel_o | output | 1 | 1 while in supervisor mode |
| int_en_o | output | 1 | 1 while interrupts are enabled |
| in_handler_o | output | 1 | Set on entry, cleared on return |
| nested_o | output | 1 | One-cycle pulse: trap taken while already in a handler |

## Verification
The bench builds the controller with its default parameters. These are a 32-bit address, three event sources, a fixed entry at 0x80000080, and a vector base of 0x80 with a shift of seven. With three sources, every vectored slot (0x80, 0x100, 0x180) can be reached, and each can be compared with the fixed entry on the same cause. The two-bit cause field leaves the unused code 3 out of reach, so the priority picker's full width is still exercised. The bench walks a chain of entries, returns, nested traps and coincident requests, in which the privilege mode saved on each entry must come back on the matching return.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN    = 32;
  localparam int N_SRC   = 3;
  localparam int CAUSE_W = $clog2(N_SRC);

  typedef logic [CAUSE_W-1:0] cause_t;

  // Source index equals cause code; lower index has higher priority.
  localparam cause_t CAUSE_UNDEF = cause_t'(0);
  localparam cause_t CAUSE_OVF   = cause_t'(1);
  localparam cause_t CAUSE_IRQ   = cause_t'(2);
endpackage

// File: rtl/exc_prio.sv
module exc_prio #(
  parameter int N = 3,
  parameter int W = 2
) (
  input  logic [N-1:0] req,
  output logic         hit,
  output logic [W-1:0] code
);
  // Scan from the top index down so the lowest active index ends up chosen.
  always_comb begin
    hit  = |req;
    code = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) code = W'(i);
    end
  end

  // The chosen source must be active, and no source ranked above it may be.
  always_comb begin
    if (hit) begin
      p_pick_active_r6: assert (req[code]);
      p_pick_highest_r6: assert ((req & ((N'(1) << code) - N'(1))) == '0);
    end
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector #(
  parameter int          XLEN      = 32,
  parameter int          W         = 2,
  parameter logic [31:0] FIXED_ADR = 32'h8000_0080,
  parameter logic [31:0] VEC_BASE  = 32'h0000_0080,
  parameter int          VEC_SHIFT = 7
) (
  input  logic            vec_mode,
  input  logic [W-1:0]    code,
  output logic [XLEN-1:0] addr
);
  localparam logic [XLEN-1:0] FIXED_X = XLEN'(FIXED_ADR);
  localparam logic [XLEN-1:0] BASE_X  = XLEN'(VEC_BASE);

  logic [XLEN-1:0] slot_off;
  assign slot_off = XLEN'(code) << VEC_SHIFT;

  always_comb begin
    addr = vec_mode ? (BASE_X + slot_off) : FIXED_X;
  end

  always_comb begin
    if (!vec_mode) p_fixed_entry_r4: assert (addr == FIXED_X);
  end
endmodule

// File: rtl/exc_status.sv
module exc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic leave,
  output logic kernel_o,
  output logic int_en_o,
  output logic in_handler_o
);
  logic kernel_q, int_en_q, inh_q, prev_kernel_q;

  // An entry outranks a return in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kernel_q      <= 1'b0;
      int_en_q      <= 1'b0;
      inh_q         <= 1'b0;
      prev_kernel_q <= 1'b0;
    end else if (enter) begin
      prev_kernel_q <= kernel_q;
      kernel_q      <= 1'b1;
      int_en_q      <= 1'b0;
      inh_q         <= 1'b1;
    end else if (leave) begin
      kernel_q <= prev_kernel_q;
      int_en_q <= 1'b1;
      inh_q    <= 1'b0;
    end
  end

  assign kernel_o     = kernel_q;
  assign int_en_o     = int_en_q;
  assign in_handler_o = inh_q;

  p_entry_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (kernel_o && !int_en_o && in_handler_o));

  p_return_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (leave && !enter) |=> (int_en_o && !in_handler_o));

  p_hold_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!leave && !enter) |=> ($stable(kernel_o) && $stable(int_en_o)));
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter logic [31:0] FIXED_ADR = 32'h8000_0080,
  parameter logic [31:0] VEC_BASE  = 32'h0000_0080,
  parameter int          VEC_SHIFT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vec_mode_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               trap_undef_i,
  input  logic               trap_ovf_i,
  input  logic               irq_i,
  input  logic               eret_i,
  output logic               redirect_valid_o,
  output logic [XLEN-1:0]    redirect_target_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [XLEN-1:0]    epc_o,
  output logic               kernel_o,
  output logic               int_en_o,
  output logic               in_handler_o,
  output logic               nested_o
);
  logic [N_SRC-1:0] req;
  logic             take;
  logic             trap;
  logic             do_ret;
  cause_t           pick;
  logic [XLEN-1:0]  entry_adr;

  logic             rv_q;
  logic [XLEN-1:0]  tgt_q;
  cause_t           cause_q;
  logic [XLEN-1:0]  epc_q;
  logic             nest_q;

  // Request vector ordered by cause code (index = code = rank).
  always_comb begin
    req = '0;
    req[CAUSE_UNDEF] = trap_undef_i;
    req[CAUSE_OVF]   = trap_ovf_i;
    req[CAUSE_IRQ]   = irq_i & int_en_o;
  end

  assign trap   = trap_undef_i | trap_ovf_i;
  assign do_ret = eret_i & ~take;

  exc_prio #(.N(N_SRC), .W(CAUSE_W)) u_prio (
    .req  (req),
    .hit  (take),
    .code (pick)
  );

  exc_vector #(
    .XLEN(XLEN), .W(CAUSE_W), .FIXED_ADR(FIXED_ADR),
    .VEC_BASE(VEC_BASE), .VEC_SHIFT(VEC_SHIFT)
  ) u_vector (
    .vec_mode (vec_mode_i),
    .code     (pick),
    .addr     (entry_adr)
  );

  exc_status u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .enter        (take),
    .leave        (eret_i),
    .kernel_o     (kernel_o),
    .int_en_o     (int_en_o),
    .in_handler_o (in_handler_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q    <= 1'b0;
      tgt_q   <= '0;
      cause_q <= '0;
      epc_q   <= '0;
      nest_q  <= 1'b0;
    end else begin
      rv_q   <= take | do_ret;
      nest_q <= trap & in_handler_o;
      if (take) begin
        tgt_q   <= entry_adr;
        cause_q <= pick;
        epc_q   <= pc_i;
      end else if (do_ret) begin
        tgt_q <= epc_q;
      end
    end
  end

  assign redirect_valid_o  = rv_q;
  assign redirect_target_o = tgt_q;
  assign cause_o           = cause_q;
  assign epc_o             = epc_q;
  assign nested_o          = nest_q;

  p_epc_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (redirect_valid_o && epc_o == $past(pc_i)));

  p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i && !int_en_o && !trap && !eret_i) |=> (!redirect_valid_o && $stable(cause_o)));

  p_nested_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && in_handler_o) |=> (nested_o && in_handler_o));

  p_trap_beats_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && eret_i) |=> (in_handler_o && !int_en_o && cause_o != CAUSE_IRQ));

  p_return_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    do_ret |=> (redirect_valid_o && redirect_target_o == epc_o));
endmodule

// File: tb/test_exc_ctrl.sv
module test_exc_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] FX = 32'h8000_0080;

  typedef struct packed {
    logic        u, o, q, e, m;
    logic [31:0] pc;
    logic        ev;
    logic [31:0] et;
    logic [1:0]  ec;
    logic        ek, ei, eh, en;
    logic [31:0] eepc;
  } vec_t;

  // Each row: inputs for one cycle, then outputs expected after that edge.
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    //  u    o    q    e    m    pc           ev   et           ec     ek   ei   eh   en   epc
    '{1'b0,1'b0,1'b1,1'b0,1'b0,32'h100,1'b0,32'h0,        2'd0,1'b0,1'b0,1'b0,1'b0,32'h0},   // R5 masked
    '{1'b0,1'b0,1'b0,1'b1,1'b0,32'h104,1'b1,32'h0,        2'd0,1'b0,1'b1,1'b0,1'b0,32'h0},   // R7
    '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h108,1'b0,32'h0,        2'd0,1'b0,1'b1,1'b0,1'b0,32'h0},   // R10
    '{1'b1,1'b0,1'b0,1'b0,1'b0,32'h200,1'b1,FX,           2'd0,1'b1,1'b0,1'b1,1'b0,32'h200}, // R2 R3 R4
    '{1'b0,1'b0,1'b1,1'b0,1'b0,32'h204,1'b0,32'h0,        2'd0,1'b1,1'b0,1'b1,1'b0,32'h200}, // R5
    '{1'b0,1'b0,1'b0,1'b1,1'b0,32'h208,1'b1,32'h200,      2'd0,1'b0,1'b1,1'b0,1'b0,32'h200}, // R7
    '{1'b0,1'b1,1'b1,1'b0,1'b1,32'h300,1'b1,32'h100,      2'd1,1'b1,1'b0,1'b1,1'b0,32'h300}, // R6 R4
    '{1'b1,1'b0,1'b0,1'b0,1'b1,32'h304,1'b1,32'h80,       2'd0,1'b1,1'b0,1'b1,1'b1,32'h304}, // R8
    '{1'b0,1'b0,1'b1,1'b0,1'b1,32'h308,1'b0,32'h0,        2'd0,1'b1,1'b0,1'b1,1'b0,32'h304}, // R10
    '{1'b0,1'b0,1'b1,1'b1,1'b1,32'h30C,1'b1,32'h304,      2'd0,1'b1,1'b1,1'b0,1'b0,32'h304}, // R7
    '{1'b0,1'b0,1'b1,1'b0,1'b1,32'h400,1'b1,32'h180,      2'd2,1'b1,1'b0,1'b1,1'b0,32'h400}, // R5 R6
    '{1'b0,1'b1,1'b0,1'b1,1'b0,32'h500,1'b1,FX,           2'd1,1'b1,1'b0,1'b1,1'b1,32'h500}, // R9
    '{1'b0,1'b0,1'b0,1'b1,1'b0,32'h504,1'b1,32'h500,      2'd1,1'b1,1'b1,1'b0,1'b0,32'h500}, // R7
    '{1'b1,1'b1,1'b0,1'b0,1'b1,32'h600,1'b1,32'h80,       2'd0,1'b1,1'b0,1'b1,1'b0,32'h600}, // R6
    '{1'b0,1'b0,1'b0,1'b1,1'b1,32'h604,1'b1,32'h600,      2'd0,1'b1,1'b1,1'b0,1'b0,32'h600}  // R7
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        vec_mode_i, trap_undef_i, trap_ovf_i, irq_i, eret_i;
  logic [31:0] pc_i;
  logic        redirect_valid_o;
  logic [31:0] redirect_target_o;
  logic [1:0]  cause_o;
  logic [31:0] epc_o;
  logic        kernel_o, int_en_o, in_handler_o, nested_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  exc_ctrl i_exc_ctrl (
    .clk(clk), .rst_n(rst_n), .vec_mode_i(vec_mode_i), .pc_i(pc_i),
    .trap_undef_i(trap_undef_i), .trap_ovf_i(trap_ovf_i), .irq_i(irq_i),
    .eret_i(eret_i), .redirect_valid_o(redirect_valid_o),
    .redirect_target_o(redirect_target_o), .cause_o(cause_o), .epc_o(epc_o),
    .kernel_o(kernel_o), .int_en_o(int_en_o), .in_handler_o(in_handler_o),
    .nested_o(nested_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic u, o, q, e, m, input logic [31:0] pc);
    trap_undef_i = u; trap_ovf_i = o; irq_i = q; eret_i = e;
    vec_mode_i = m; pc_i = pc;
  endtask

  task automatic check_reset_state(input string tag);
    chk({tag, " R1 kernel"},   32'(kernel_o), 0);
    chk({tag, " R1 int_en"},   32'(int_en_o), 0);
    chk({tag, " R1 in_handler"}, 32'(in_handler_o), 0);
    chk({tag, " R1 nested"},   32'(nested_o), 0);
    chk({tag, " R1 redirect"}, 32'(redirect_valid_o), 0);
    chk({tag, " R1 cause"},    32'(cause_o), 0);
    chk({tag, " R1 epc"},      epc_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state("reset");
    rst_n = 1'b1;

    // Vector table walk: drive at a falling edge, check at the next one.
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].u, VEC[i].o, VEC[i].q, VEC[i].e, VEC[i].m, VEC[i].pc);
      @(negedge clk);
      chk($sformatf("vec%0d R2 redirect_valid", i), 32'(redirect_valid_o), 32'(VEC[i].ev));
      if (VEC[i].ev)
        chk($sformatf("vec%0d R4/R7 target", i), redirect_target_o, VEC[i].et);
      chk($sformatf("vec%0d R2 cause", i), 32'(cause_o), 32'(VEC[i].ec));
      chk($sformatf("vec%0d R2 epc", i), epc_o, VEC[i].eepc);
      chk($sformatf("vec%0d R3 kernel", i), 32'(kernel_o), 32'(VEC[i].ek));
      chk($sformatf("vec%0d R3 int_en", i), 32'(int_en_o), 32'(VEC[i].ei));
      chk($sformatf("vec%0d R3 in_handler", i), 32'(in_handler_o), 32'(VEC[i].eh));
      chk($sformatf("vec%0d R8 nested", i), 32'(nested_o), 32'(VEC[i].en));
    end

    // R2: redirect is a single-cycle pulse when the next cycle is idle.
    drive(1, 0, 0, 0, 0, 32'h700);
    @(negedge clk);
    chk("R2 pulse high", 32'(redirect_valid_o), 1);
    drive(0, 0, 0, 0, 0, 32'h704);
    @(negedge clk);
    chk("R2 pulse low", 32'(redirect_valid_o), 0);
    chk("R8 nested drops", 32'(nested_o), 0);
    chk("R10 epc held", epc_o, 32'h700);

    // R5/R6: irq lost to a trap, then taken after return while still high.
    drive(0, 0, 0, 1, 1, 32'h708);
    @(negedge clk);
    drive(0, 1, 1, 0, 1, 32'h800);
    @(negedge clk);
    chk("R6 overflow first", 32'(cause_o), 1);
    drive(0, 0, 1, 1, 1, 32'h804);
    @(negedge clk);
    chk("R7 back", 32'(int_en_o), 1);
    drive(0, 0, 1, 0, 1, 32'h900);
    @(negedge clk);
    chk("R6 pending irq cause", 32'(cause_o), 2);
    chk("R4 irq slot", redirect_target_o, 32'h180);
    chk("R2 irq epc", epc_o, 32'h900);

    // R1: reset in mid-run clears everything.
    drive(0, 0, 0, 0, 0, 32'h0);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state("midrun");
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule